// File: doc/BRIEF.md
# Fetch-Stage Next-PC Predictor

The block predicts the next fetch address of an instruction stream. Each fetch PC is looked up in a direct-mapped, tagged branch target buffer while the instruction itself is being fetched. One clock later the block reports whether a branch was found, whether it is predicted taken, and the address to fetch next. A later pipeline stage reports each resolved branch on a resolve port: its PC, its actual direction and target, and the prediction it was given. The block uses this report to update its tables and flags a misprediction one clock later.

A parameter selects one of two organizations. In the coupled organization every resolved branch owns a buffer entry, and each entry holds a 2-bit saturating direction counter. A buffer miss predicts not taken. In the uncoupled organization the buffer keeps only branches whose last outcome was taken, so a hit means taken. A miss falls back to a separate untagged table of 2-bit counters, which only supplies the direction. The fetch address then stays sequential, because no target is known.

Top module: `next_pc_predictor`

## Requirements
- R1: Lookup takes one clock. `pred_valid` equals `fetch_valid` from the previous clock. While `pred_valid` is low, `pred_hit`, `pred_taken` and `pred_next_pc` are all zero.
- R2: Synchronous reset clears every buffer valid bit and sets every 2-bit counter, in the buffer and in the history table, to 01 (weakly not taken). During reset, all outputs are driven low.
- R3: A PC selects a buffer entry by its bits [ALIGN_BITS+log2(BTB_ENTRIES)-1 : ALIGN_BITS]. The bits above those form the tag. A hit requires the entry to be valid and its tag to be equal, so two PCs that share an index but differ in tag never hit on each other's entry.
- R4: When a lookup is a hit and is predicted taken, `pred_next_pc` is the stored target. In every other case it is the fetch PC plus INST_BYTES.
- R5: In the coupled organization, the direction of a hit is bit 1 of the entry's counter. A resolve that matches the entry moves the counter up by one if the branch was taken and down by one if not, saturating at 00 and 11.
- R6: In the coupled organization, a miss predicts not taken. A resolve that misses allocates the entry: it sets the valid bit, the tag and the target, and seeds the counter with 10 if the branch was taken and 01 if not.
- R7: In the uncoupled organization, a hit predicts taken and redirects to the stored target.
- R8: In the uncoupled organization, a miss takes its direction from bit 1 of the history-table counter selected by PC bits [ALIGN_BITS+log2(BHT_ENTRIES)-1 : ALIGN_BITS], and `pred_next_pc` stays sequential. Every resolved branch steps that counter up if taken and down if not, saturating.
- R9: In the uncoupled organization, a resolved taken branch installs or overwrites its entry. A resolved not-taken branch clears the valid bit of an entry whose tag matches, and leaves a non-matching entry alone.
- R10: A resolved taken branch that matches an entry writes its actual target into that entry, so that a wrong stored target is corrected.
- R11: `res_mispredict` is high one clock after a resolve in exactly three cases: the branch was predicted taken but was not taken; it was predicted not taken but was taken; or it was predicted taken and was taken, but the predicted target differs from the actual target.
- R12: A lookup in the same clock as a resolve write sees the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | A fetch PC is presented |
| fetch_pc | input | PC_W | Fetch address to look up |
| pred_valid | output | 1 | Prediction for the previous fetch is valid |
| pred_hit | output | 1 | Buffer hit |
| pred_taken | output | 1 | Predicted direction |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | A resolved branch is reported |
| res_pc | input | PC_W | PC of the resolved branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | PC_W | Actual taken target |
| res_pred_taken | input | 1 | Direction that was predicted for this branch |
| res_pred_target | input | PC_W | Next PC that was predicted for this branch |
| res_mispredict | output | 1 | Misprediction flag, one clock after the resolve |

## Verification
Both organizations are driven side by side from the same stimulus. Directed sequences come first: a branch taken several times and then not taken, which separates counter hysteresis from a one-bit scheme; a not-taken resolve colliding with a lookup of the same PC, which shows that a lookup reads the table before the write; and two PCs that share an index but differ in tag, which shows that the tag comparison works. Another pair of PCs shares a history-table slot but not a buffer tag, which shows that the uncoupled fallback direction is independent of the buffer. The four combinations of predicted and actual direction and target separate the three misprediction causes from a correct prediction. A long random mix over a small address pool then forces repeated allocation, replacement and invalidation.

// File: rtl/npp_pkg.sv
package npp_pkg;
   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_WEAK_NT = 2'b01;
   localparam ctr2_t CTR_WEAK_T  = 2'b10;

   // saturating up/down step of a 2-bit direction counter
   function automatic ctr2_t ctr_step(ctr2_t cur, logic up);
      ctr2_t res;
      if (up) res = (cur == 2'b11) ? cur : cur + 2'd1;
      else    res = (cur == 2'b00) ? cur : cur - 2'd1;
      return res;
   endfunction

   // initial counter for a freshly allocated entry
   function automatic ctr2_t ctr_seed(logic taken);
      return taken ? CTR_WEAK_T : CTR_WEAK_NT;
   endfunction
endpackage

// File: rtl/npp_bht.sv
module npp_bht
   import npp_pkg::*;
#(
   parameter int ENTRIES = 64,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr2_t            rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("npp_bht: ENTRIES must be a power of two >= 2");
   end

   ctr2_t ctr_q [ENTRIES];

   assign rd_ctr = ctr_q[rd_idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WEAK_NT;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
      end
   end
endmodule

// File: rtl/npp_btb.sv
module npp_btb
   import npp_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 26,
   parameter int TGT_W   = 32,
   parameter bit COUPLED = 1'b1,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic [TGT_W-1:0] rd_tgt,
   output ctr2_t            rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_taken,
   input  logic [TGT_W-1:0] wr_tgt
);
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("npp_btb: ENTRIES must be a power of two >= 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("npp_btb: TAG_W must be at least 1");
   end

   logic [ENTRIES-1:0] vld_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [TGT_W-1:0]   tgt_q [ENTRIES];
   ctr2_t              ctr_q [ENTRIES];

   // read side: reads the registered state, so a same-cycle write is not seen
   assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_tgt = tgt_q[rd_idx];
   assign rd_ctr = ctr_q[rd_idx];

   logic             wr_match;
   logic             do_wr;
   logic             nxt_vld;
   logic [TGT_W-1:0] nxt_tgt;
   ctr2_t            nxt_ctr;

   assign wr_match = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);

   if (COUPLED) begin : g_coupled
      // every resolved branch owns an entry; counter lives in the entry
      always_comb begin
         do_wr   = wr_en;
         nxt_vld = 1'b1;
         nxt_tgt = (!wr_match || wr_taken) ? wr_tgt : tgt_q[wr_idx];
         nxt_ctr = wr_match ? ctr_step(ctr_q[wr_idx], wr_taken)
                            : ctr_seed(wr_taken);
      end
   end else begin : g_uncoupled
      // only taken branches live here; not-taken evicts a matching entry
      always_comb begin
         do_wr   = wr_en && (wr_taken || wr_match);
         nxt_vld = wr_taken;
         nxt_tgt = wr_taken ? wr_tgt : tgt_q[wr_idx];
         nxt_ctr = wr_taken ? CTR_WEAK_T : ctr_q[wr_idx];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            tag_q[i] <= '0;
            tgt_q[i] <= '0;
            ctr_q[i] <= CTR_WEAK_NT;
         end
      end else if (do_wr) begin
         vld_q[wr_idx] <= nxt_vld;
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= nxt_tgt;
         ctr_q[wr_idx] <= nxt_ctr;
      end
   end
endmodule

// File: rtl/next_pc_predictor.sv
module next_pc_predictor
   import npp_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int TGT_W       = 32,
   parameter int BTB_ENTRIES = 16,
   parameter int BHT_ENTRIES = 64,
   parameter int ALIGN_BITS  = 2,
   parameter int INST_BYTES  = 4,
   parameter bit COUPLED     = 1'b1,
   localparam int BTB_IDX_W = $clog2(BTB_ENTRIES),
   localparam int BHT_IDX_W = $clog2(BHT_ENTRIES),
   localparam int TAG_W     = PC_W - ALIGN_BITS - BTB_IDX_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            fetch_valid,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_valid,
   output logic            pred_hit,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_next_pc,
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_target,
   input  logic            res_pred_taken,
   input  logic [PC_W-1:0] res_pred_target,
   output logic            res_mispredict
);
   if (ALIGN_BITS < 1 || TAG_W < 1) begin : g_bad_geom
      $error("next_pc_predictor: ALIGN_BITS >= 1 and a non-empty tag are required");
   end
   if (TGT_W > PC_W || TGT_W < 1) begin : g_bad_tgt
      $error("next_pc_predictor: TGT_W must lie in 1..PC_W");
   end
   if (ALIGN_BITS + BHT_IDX_W > PC_W) begin : g_bad_bht
      $error("next_pc_predictor: history index exceeds PC width");
   end

   // ---------------- address split ----------------
   logic [BTB_IDX_W-1:0] f_idx, r_idx;
   logic [TAG_W-1:0]     f_tag, r_tag;
   logic [BHT_IDX_W-1:0] f_hidx, r_hidx;

   assign f_idx  = fetch_pc[ALIGN_BITS +: BTB_IDX_W];
   assign r_idx  = res_pc[ALIGN_BITS +: BTB_IDX_W];
   assign f_tag  = fetch_pc[PC_W-1 -: TAG_W];
   assign r_tag  = res_pc[PC_W-1 -: TAG_W];
   assign f_hidx = fetch_pc[ALIGN_BITS +: BHT_IDX_W];
   assign r_hidx = res_pc[ALIGN_BITS +: BHT_IDX_W];

   // ---------------- target buffer ----------------
   logic             btb_hit;
   logic [TGT_W-1:0] btb_tgt;
   ctr2_t            btb_ctr;

   npp_btb #(
      .ENTRIES (BTB_ENTRIES),
      .TAG_W   (TAG_W),
      .TGT_W   (TGT_W),
      .COUPLED (COUPLED)
   ) u_btb (
      .clk      (clk),
      .rst      (rst),
      .rd_idx   (f_idx),
      .rd_tag   (f_tag),
      .rd_hit   (btb_hit),
      .rd_tgt   (btb_tgt),
      .rd_ctr   (btb_ctr),
      .wr_en    (res_valid),
      .wr_idx   (r_idx),
      .wr_tag   (r_tag),
      .wr_taken (res_taken),
      .wr_tgt   (res_target[TGT_W-1:0])
   );

   // ---------------- direction choice ----------------
   ctr2_t bht_ctr;
   logic  dir_taken;

   if (COUPLED) begin : g_dir_coupled
      assign bht_ctr   = CTR_WEAK_NT;
      assign dir_taken = btb_hit && btb_ctr[1];
   end else begin : g_dir_uncoupled
      npp_bht #(
         .ENTRIES (BHT_ENTRIES)
      ) u_bht (
         .clk      (clk),
         .rst      (rst),
         .rd_idx   (f_hidx),
         .rd_ctr   (bht_ctr),
         .wr_en    (res_valid),
         .wr_idx   (r_hidx),
         .wr_taken (res_taken)
      );
      assign dir_taken = btb_hit ? 1'b1 : bht_ctr[1];
   end

   // ---------------- target width expansion ----------------
   logic [PC_W-1:0] tgt_full;

   if (TGT_W == PC_W) begin : g_tgt_full
      assign tgt_full = btb_tgt;
   end else begin : g_tgt_part
      assign tgt_full = {fetch_pc[PC_W-1:TGT_W], btb_tgt};
   end

   logic            redirect;
   logic [PC_W-1:0] next_pc;

   assign redirect = btb_hit && dir_taken;
   assign next_pc  = redirect ? tgt_full : fetch_pc + PC_W'(INST_BYTES);

   // ---------------- output registers ----------------
   logic mp_now;
   assign mp_now = (res_pred_taken != res_taken) ||
                   (res_pred_taken && res_taken && (res_pred_target != res_target));

   always_ff @(posedge clk) begin
      if (rst) begin
         pred_valid     <= 1'b0;
         pred_hit       <= 1'b0;
         pred_taken     <= 1'b0;
         pred_next_pc   <= '0;
         res_mispredict <= 1'b0;
      end else begin
         pred_valid     <= fetch_valid;
         pred_hit       <= fetch_valid && btb_hit;
         pred_taken     <= fetch_valid && dir_taken;
         pred_next_pc   <= fetch_valid ? next_pc : '0;
         res_mispredict <= res_valid && mp_now;
      end
   end

   logic unused_bits;
   assign unused_bits = ^{res_pc[ALIGN_BITS-1:0], res_target, btb_ctr, bht_ctr};
endmodule

// File: rtl/npp_checker.sv
module npp_checker #(
   parameter int PC_W       = 32,
   parameter int INST_BYTES = 4,
   parameter bit COUPLED    = 1'b1
) (
   input logic            clk,
   input logic            rst,
   input logic            fetch_valid,
   input logic [PC_W-1:0] fetch_pc,
   input logic            pred_valid,
   input logic            pred_hit,
   input logic            pred_taken,
   input logic [PC_W-1:0] pred_next_pc,
   input logic            res_valid,
   input logic            res_taken,
   input logic [PC_W-1:0] res_target,
   input logic            res_pred_taken,
   input logic [PC_W-1:0] res_pred_target,
   input logic            res_mispredict
);
   // armed: the previous edge was outside reset, so $past values are meaningful
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= !rst;

   p_reset_quiet_r2: assert property (@(posedge clk)
      rst |=> (!pred_valid && !pred_hit && !pred_taken && !res_mispredict));

   p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
      armed |-> (pred_valid == $past(fetch_valid)));

   p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
      !pred_valid |-> (!pred_hit && !pred_taken && pred_next_pc == '0));

   p_seq_next_r4: assert property (@(posedge clk) disable iff (rst)
      (armed && pred_valid && !(pred_hit && pred_taken))
         |-> (pred_next_pc == $past(fetch_pc) + PC_W'(INST_BYTES)));

   p_miss_not_taken_r6: assert property (@(posedge clk) disable iff (rst)
      (COUPLED && pred_valid && !pred_hit) |-> !pred_taken);

   p_hit_taken_r7: assert property (@(posedge clk) disable iff (rst)
      (!COUPLED && pred_hit) |-> pred_taken);

   p_mispredict_r11: assert property (@(posedge clk) disable iff (rst)
      armed |-> (res_mispredict ==
         ($past(res_valid) &&
          (($past(res_pred_taken) != $past(res_taken)) ||
           ($past(res_pred_taken) && $past(res_taken) &&
            $past(res_pred_target) != $past(res_target))))));
endmodule

bind next_pc_predictor npp_checker #(
   .PC_W       (PC_W),
   .INST_BYTES (INST_BYTES),
   .COUPLED    (COUPLED)
) u_npp_checker (
   .clk             (clk),
   .rst             (rst),
   .fetch_valid     (fetch_valid),
   .fetch_pc        (fetch_pc),
   .pred_valid      (pred_valid),
   .pred_hit        (pred_hit),
   .pred_taken      (pred_taken),
   .pred_next_pc    (pred_next_pc),
   .res_valid       (res_valid),
   .res_taken       (res_taken),
   .res_target      (res_target),
   .res_pred_taken  (res_pred_taken),
   .res_pred_target (res_pred_target),
   .res_mispredict  (res_mispredict)
);

// File: tb/next_pc_predictor_bench.sv
`timescale 1ns/1ps
module next_pc_predictor_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        res_valid = 1'b0;
   logic [31:0] res_pc = '0;
   logic        res_taken = 1'b0;
   logic [31:0] res_target = '0;
   logic        res_pred_taken = 1'b0;
   logic [31:0] res_pred_target = '0;

   logic        c_pv, c_ph, c_pt, c_mp;
   logic [31:0] c_np;
   logic        u_pv, u_ph, u_pt, u_mp;
   logic [31:0] u_np;

   always #2 clk = ~clk;  // 250 MHz

   next_pc_predictor #(.COUPLED(1'b1)) u_next_pc_predictor (
      .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .pred_valid(c_pv), .pred_hit(c_ph), .pred_taken(c_pt), .pred_next_pc(c_np),
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
      .res_target(res_target), .res_pred_taken(res_pred_taken),
      .res_pred_target(res_pred_target), .res_mispredict(c_mp));

   next_pc_predictor #(.COUPLED(1'b0)) u_next_pc_predictor_unc (
      .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .pred_valid(u_pv), .pred_hit(u_ph), .pred_taken(u_pt), .pred_next_pc(u_np),
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
      .res_target(res_target), .res_pred_taken(res_pred_taken),
      .res_pred_target(res_pred_target), .res_mispredict(u_mp));

   // ---------------- reference model ----------------
   logic        mc_vld [16];
   logic [25:0] mc_tag [16];
   logic [31:0] mc_tgt [16];
   logic [1:0]  mc_ctr [16];
   logic        mu_vld [16];
   logic [25:0] mu_tag [16];
   logic [31:0] mu_tgt [16];
   logic [1:0]  mh_ctr [64];

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   function automatic logic [1:0] sat2(logic [1:0] c, logic up);
      if (up) return (c == 2'd3) ? c : c + 2'd1;
      return (c == 2'd0) ? c : c - 2'd1;
   endfunction

   function automatic logic mp_ref(logic pt, logic t, logic [31:0] ptg, logic [31:0] tg);
      return (pt != t) || (pt && t && ptg != tg);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 16; i++) begin
         mc_vld[i] = 1'b0; mc_tag[i] = '0; mc_tgt[i] = '0; mc_ctr[i] = 2'b01;
         mu_vld[i] = 1'b0; mu_tag[i] = '0; mu_tgt[i] = '0;
      end
      for (int i = 0; i < 64; i++) mh_ctr[i] = 2'b01;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, predict from model, update model, compare at next negedge
   task automatic step(input logic fv, input logic [31:0] fpc,
                       input logic rv, input logic [31:0] rpc, input logic rt,
                       input logic [31:0] rtgt, input logic rpt, input logic [31:0] rptgt,
                       input string req);
      logic [3:0]  fi, ri;
      logic [25:0] ft, rtg;
      logic [5:0]  fh, rh;
      logic        ec_h, ec_t, eu_h, eu_t, e_mp;
      logic [31:0] ec_n, eu_n;
      fetch_valid = fv; fetch_pc = fpc;
      res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtgt;
      res_pred_taken = rpt; res_pred_target = rptgt;
      fi = fpc[5:2]; ft = fpc[31:6]; fh = fpc[7:2];
      ri = rpc[5:2]; rtg = rpc[31:6]; rh = rpc[7:2];
      // expected prediction uses state before this clock's write (R12)
      ec_h = mc_vld[fi] && mc_tag[fi] == ft;
      ec_t = ec_h && mc_ctr[fi][1];
      ec_n = ec_t ? mc_tgt[fi] : fpc + 32'd4;
      eu_h = mu_vld[fi] && mu_tag[fi] == ft;
      eu_t = eu_h ? 1'b1 : mh_ctr[fh][1];
      eu_n = eu_h ? mu_tgt[fi] : fpc + 32'd4;
      if (!fv) begin
         ec_h = 0; ec_t = 0; ec_n = '0; eu_h = 0; eu_t = 0; eu_n = '0;
      end
      e_mp = rv && mp_ref(rpt, rt, rptgt, rtgt);
      if (rv) begin
         if (mc_vld[ri] && mc_tag[ri] == rtg) begin
            mc_ctr[ri] = sat2(mc_ctr[ri], rt);
            if (rt) mc_tgt[ri] = rtgt;
         end else begin
            mc_vld[ri] = 1'b1; mc_tag[ri] = rtg; mc_tgt[ri] = rtgt;
            mc_ctr[ri] = rt ? 2'b10 : 2'b01;
         end
         if (rt) begin
            mu_vld[ri] = 1'b1; mu_tag[ri] = rtg; mu_tgt[ri] = rtgt;
         end else if (mu_vld[ri] && mu_tag[ri] == rtg) begin
            mu_vld[ri] = 1'b0;
         end
         mh_ctr[rh] = sat2(mh_ctr[rh], rt);
      end
      @(negedge clk);
      check(c_pv == fv, {req, " R1"}, "coupled pred_valid", 32'(c_pv), 32'(fv));
      check(c_ph == ec_h, {req, " R3"}, "coupled pred_hit", 32'(c_ph), 32'(ec_h));
      check(c_pt == ec_t, {req, " R5"}, "coupled pred_taken", 32'(c_pt), 32'(ec_t));
      check(c_np == ec_n, {req, " R4"}, "coupled pred_next_pc", c_np, ec_n);
      check(u_pv == fv, {req, " R1"}, "uncoupled pred_valid", 32'(u_pv), 32'(fv));
      check(u_ph == eu_h, {req, " R9"}, "uncoupled pred_hit", 32'(u_ph), 32'(eu_h));
      check(u_pt == eu_t, {req, " R8"}, "uncoupled pred_taken", 32'(u_pt), 32'(eu_t));
      check(u_np == eu_n, {req, " R7"}, "uncoupled pred_next_pc", u_np, eu_n);
      check(c_mp == e_mp, {req, " R11"}, "coupled res_mispredict", 32'(c_mp), 32'(e_mp));
      check(u_mp == e_mp, {req, " R11"}, "uncoupled res_mispredict", 32'(u_mp), 32'(e_mp));
   endtask

   task automatic lookup(input logic [31:0] pc, input string req);
      step(1'b1, pc, 1'b0, '0, 1'b0, '0, 1'b0, '0, req);
   endtask

   task automatic resolve(input logic [31:0] pc, input logic t, input logic [31:0] tg,
                          input string req);
      step(1'b0, '0, 1'b1, pc, t, tg, 1'b0, '0, req);
   endtask

   localparam logic [31:0] PA = 32'h0000_0100;
   localparam logic [31:0] PB = 32'h0000_0140;  // same entry index as PA, other tag
   localparam logic [31:0] PC = 32'h0000_0200;
   localparam logic [31:0] PD = 32'h0000_0300;  // same history slot as PC, other tag

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R2: outputs low straight out of reset
      check(!c_pv && !c_ph && !c_pt && c_np == '0 && !c_mp, "R2", "coupled reset outputs",
            {c_np[27:0], c_pv, c_ph, c_pt, c_mp}, 32'h0);
      check(!u_pv && !u_ph && !u_pt && u_np == '0 && !u_mp, "R2", "uncoupled reset outputs",
            {u_np[27:0], u_pv, u_ph, u_pt, u_mp}, 32'h0);
      lookup(PA, "R2");                                  // empty tables: miss, weakly not taken
      resolve(PA, 1'b1, 32'h800, "R6");                  // allocate seeded 10 / install
      lookup(PA, "R6");                                  // hit, taken to 0x800
      step(1'b1, PA, 1'b1, PA, 1'b0, 32'h800, 1'b1, 32'h800, "R12");  // old state seen
      lookup(PA, "R9");                                  // coupled 01, uncoupled evicted
      lookup(PB, "R3");                                  // alias index, other tag: miss
      resolve(PA, 1'b1, 32'h900, "R10");
      resolve(PA, 1'b1, 32'h940, "R10");                 // correct target, ctr toward 11
      resolve(PA, 1'b1, 32'h940, "R5");
      lookup(PA, "R10");
      resolve(PA, 1'b0, 32'h940, "R5");                  // 11 -> 10 still taken
      lookup(PA, "R5");
      resolve(PB, 1'b0, 32'h0, "R9");                    // non-matching not-taken leaves PA
      lookup(PA, "R9");
      resolve(PD, 1'b1, 32'hA00, "R8");
      resolve(PD, 1'b1, 32'hA00, "R8");                  // history slot now 11
      lookup(PC, "R8");                                  // uncoupled: miss, taken, sequential
      // R11: the three misprediction causes and one correct prediction
      step(1'b0, '0, 1'b1, PC, 1'b0, 32'h10, 1'b1, 32'h10, "R11");
      step(1'b0, '0, 1'b1, PC, 1'b1, 32'h10, 1'b0, 32'h0, "R11");
      step(1'b0, '0, 1'b1, PC, 1'b1, 32'h10, 1'b1, 32'h14, "R11");
      step(1'b0, '0, 1'b1, PC, 1'b1, 32'h10, 1'b1, 32'h10, "R11");
      // constrained random mix
      process::self().srandom(32'd2718);
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] fpc, rpc, tg, ptg;
         logic rt, rpt;
         fpc = 32'h4000 | ({30'($urandom_range(0, 3)), 8'h0} ) | {$urandom_range(0, 63), 2'b00};
         rpc = 32'h4000 | ({30'($urandom_range(0, 3)), 8'h0} ) | {$urandom_range(0, 63), 2'b00};
         tg  = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
         rt  = ($urandom_range(0, 99) < 60);
         rpt = $urandom_range(0, 1);
         ptg = ($urandom_range(0, 3) == 0) ? {$urandom_range(0, 32'h3FFF_FFFF), 2'b00} : tg;
         step($urandom_range(0, 3) != 0, fpc, $urandom_range(0, 1), rpc, rt, tg, rpt, ptg,
              "RND");
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule